// File: doc/BRIEF.md
# Byte-Port DES Cipher Engine

This block encrypts or decrypts 64-bit blocks with the Data Encryption Standard. A host pushes a block in through an 8-bit write port, one byte per strobe, and pulls the result out through a separate 8-bit read port. The engine holds one block in its input register, one block in the cipher core and one block in its output register, so loading, ciphering and unloading overlap. Two flags pace the host: `in_rdy` says a write strobe will be taken, and `out_avail` says a read strobe will return a valid byte.

The core runs one Feistel round per clock. The S-box tables and the key schedule are built into the block. Electronic codebook and cipher block chaining modes are both supported, with the same timing. A single-cycle configuration strobe loads the 64-bit key, the 64-bit initial chaining value and the mode bits. It also clears the error flag. This strobe is only to be used while the engine is empty.

With one block in flight, the last result byte leaves 39 clocks after the first input byte arrives. When the host keeps both ports busy, one block completes every 18 clocks.

Top module: `des_byte_engine`

## Requirements
- R1: Byte k of a block (k = 0..7, in strobe order) maps to bits [63-8k:56-8k] of the 64-bit word, on both the write port and the read port. Byte 0 is the most significant byte.
- R2: Counting the clock that samples the first byte as clock 0, `in_rdy` is low from clock 8, after the 8th write. If the core is free, `in_rdy` is high again at clock 13.
- R3: With the engine otherwise empty, `out_avail` first goes high at clock 31. This is 18 cipher clocks plus 5 transfer clocks after the last input byte.
- R4: Eight read strobes return the block. The last read is at clock 38, and `out_avail` is low at clock 39.
- R5: When the host writes whenever `in_rdy` is high and reads whenever `out_avail` is high, successive results become available exactly 18 clocks apart.
- R6: With `cfg_dec`=0 and `cfg_cbc`=0, each block is DES-encrypted independently with the loaded key.
- R7: With `cfg_dec`=1 and `cfg_cbc`=0, each block is DES-decrypted independently. The subkeys are used in reverse order.
- R8: With `cfg_dec`=0 and `cfg_cbc`=1, each plaintext is XORed with the chaining value before encryption. The chaining value is the loaded IV for the first block and the previous ciphertext after that. This holds for back-to-back blocks too.
- R9: With `cfg_dec`=1 and `cfg_cbc`=1, the decrypted core output is XORed with the previous ciphertext, or with the IV for the first block. Each incoming ciphertext becomes the next chaining value.
- R10: A write strobe while `in_rdy` is low is ignored: no byte enters the block. It sets `err`.
- R11: A read strobe while `out_avail` is low is ignored: no byte is consumed. It sets `err`.
- R12: After reset, `in_rdy`=1, `out_avail`=0 and `err`=0.
- R13: `cfg_ld` latches `key_in`, `iv_in`, `cfg_dec` and `cfg_cbc`, and clears `err`. Otherwise `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ld | input | 1 | Load key, IV and mode; clear error |
| cfg_dec | input | 1 | 1 = decrypt, 0 = encrypt |
| cfg_cbc | input | 1 | 1 = chained mode, 0 = codebook mode |
| key_in | input | 64 | DES key, parity bits ignored |
| iv_in | input | 64 | Initial chaining value |
| wr | input | 1 | Write strobe |
| din | input | 8 | Write byte |
| in_rdy | output | 1 | Write strobe will be accepted |
| rd | input | 1 | Read strobe |
| dout | output | 8 | Current result byte |
| out_avail | output | 1 | Read strobe will be accepted |
| err | output | 1 | Sticky flag for a rejected strobe |

## Verification
The assertions assume `cfg_ld` is pulsed only when no block is inside the engine, and that `wr` and `rd` stay low during reset. They also treat each strobe as one byte transfer, so a held strobe counts as one access per clock. The bench changes configuration only after the previous result has been fully read. It drives strobes for a single clock each, and it issues deliberately rejected strobes only at points where a flag is known to be low. That way each error case touches exactly one rule.

// File: rtl/des_byte_engine.sv
module des_byte_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_ld,
  input  logic        cfg_dec,
  input  logic        cfg_cbc,
  input  logic [63:0] key_in,
  input  logic [63:0] iv_in,
  input  logic        wr,
  input  logic [7:0]  din,
  output logic        in_rdy,
  input  logic        rd,
  output logic [7:0]  dout,
  output logic        out_avail,
  output logic        err
);
  localparam int BYTES  = 8;
  localparam int XFER   = 5;
  localparam int ROUNDS = 16;
  localparam int DONE   = ROUNDS + 2;

  localparam int IP_T [64] = '{58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
                               62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
                               57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
                               61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};
  localparam int FP_T [64] = '{40,8,48,16,56,24,64,32, 39,7,47,15,55,23,63,31,
                               38,6,46,14,54,22,62,30, 37,5,45,13,53,21,61,29,
                               36,4,44,12,52,20,60,28, 35,3,43,11,51,19,59,27,
                               34,2,42,10,50,18,58,26, 33,1,41,9,49,17,57,25};
  localparam int P_T [32] = '{16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
                              2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};
  localparam int PC1_T [56] = '{57,49,41,33,25,17,9, 1,58,50,42,34,26,18,
                                10,2,59,51,43,35,27, 19,11,3,60,52,44,36,
                                63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
                                14,6,61,53,45,37,29, 21,13,5,28,20,12,4};
  localparam int PC2_T [48] = '{14,17,11,24,1,5, 3,28,15,6,21,10, 23,19,12,4,26,8,
                                16,7,27,20,13,2, 41,52,31,37,47,55, 30,40,51,45,33,48,
                                44,49,39,56,34,53, 46,42,50,36,29,32};
  localparam int SH_T [16] = '{1,2,4,6,8,10,12,14,15,17,19,21,23,25,27,28};
  localparam logic [63:0] SB_T [32] = '{
    64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
    64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
    64'hA09E63F51DC7B428, 64'hD70934A6285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
    64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
    64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
    64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
    64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
    64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};

  function automatic logic [63:0] perm64(input logic [63:0] x, input logic fin);
    logic [63:0] o;
    for (int i = 0; i < 64; i++) o[63-i] = x[64 - (fin ? FP_T[i] : IP_T[i])];
    return o;
  endfunction

  function automatic logic [47:0] expand(input logic [31:0] r);
    logic [47:0] o;
    for (int i = 0; i < 48; i++) o[47-i] = r[31 - ((4*(i/6) + (i%6) + 31) % 32)];
    return o;
  endfunction

  function automatic logic [47:0] subkey(input logic [63:0] k, input logic [3:0] idx);
    logic [55:0] cd, tc, td, rot;
    logic [47:0] o;
    for (int i = 0; i < 56; i++) cd[55-i] = k[64 - PC1_T[i]];
    tc = {cd[55:28], cd[55:28]} << SH_T[idx];
    td = {cd[27:0], cd[27:0]} << SH_T[idx];
    rot = {tc[55:28], td[55:28]};
    for (int i = 0; i < 48; i++) o[47-i] = rot[56 - PC2_T[i]];
    return o;
  endfunction

  function automatic logic [63:0] feistel(input logic [63:0] s, input logic [47:0] k);
    logic [47:0] x;
    logic [31:0] sb, pf;
    logic [5:0]  b;
    x = expand(s[31:0]) ^ k;
    for (int j = 0; j < 8; j++) begin
      b = x[47-6*j -: 6];
      sb[31-4*j -: 4] = SB_T[4*j + int'({b[5], b[0]})][63 - 4*int'(b[4:1]) -: 4];
    end
    for (int i = 0; i < 32; i++) pf[31-i] = sb[32 - P_T[i]];
    return {s[31:0], s[63:32] ^ pf};
  endfunction

  logic [63:0] key_r, chain, xr, st, sreg, obuf;
  logic        dec_r, cbc_r, full, err_r;
  logic [2:0]  ib, xin, xout;
  logic [3:0]  ocnt;
  logic [4:0]  cnt;

  logic        wr_ok, rd_ok, last, ofree, emit, take;
  logic [63:0] word, res, chain_eff, blk_in;
  logic [3:0]  kidx;

  assign in_rdy    = !full && xin == 3'd0;
  assign out_avail = ocnt != 4'd0 && xout == 3'd0;
  assign dout      = obuf[63:56];
  assign err       = err_r;

  assign wr_ok  = wr && in_rdy;
  assign rd_ok  = rd && out_avail;
  assign last   = wr_ok && ib == 3'(BYTES - 1);
  assign ofree  = ocnt == 4'd0 || (ocnt == 4'd1 && rd_ok);
  assign emit   = cnt == 5'(DONE) && ofree;
  assign take   = (cnt == 5'd0 || emit) && (full || last);
  assign word   = full ? sreg : {sreg[55:0], din};
  assign res    = perm64({st[31:0], st[63:32]}, 1'b1) ^ ((cbc_r && dec_r) ? xr : 64'd0);
  assign chain_eff = (emit && !dec_r) ? res : chain;
  assign blk_in = (cbc_r && !dec_r) ? (word ^ chain_eff) : word;
  assign kidx   = dec_r ? 4'd15 - (cnt[3:0] - 4'd2) : cnt[3:0] - 4'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_r <= '0; chain <= '0; dec_r <= 1'b0; cbc_r <= 1'b0; err_r <= 1'b0;
    end else if (cfg_ld) begin
      key_r <= key_in; chain <= iv_in; dec_r <= cfg_dec; cbc_r <= cfg_cbc; err_r <= 1'b0;
    end else begin
      if ((wr && !in_rdy) || (rd && !out_avail)) err_r <= 1'b1;
      if (take && dec_r) chain <= word;
      else if (emit && !dec_r) chain <= res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0; ib <= '0; full <= 1'b0; xin <= '0;
    end else begin
      if (wr_ok) begin
        sreg <= {sreg[55:0], din};
        ib   <= last ? 3'd0 : ib + 3'd1;
      end
      if (take && full) full <= 1'b0;
      else if (last && !take) full <= 1'b1;
      if (last) xin <= 3'(XFER);
      else if (xin != 3'd0) xin <= xin - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0; xr <= '0; cnt <= '0;
    end else if (take) begin
      st <= blk_in; xr <= chain; cnt <= 5'd1;
    end else if (cnt == 5'd1) begin
      st <= perm64(st, 1'b0); cnt <= 5'd2;
    end else if (cnt == 5'(DONE)) begin
      if (emit) cnt <= 5'd0;
    end else if (cnt != 5'd0) begin
      st <= feistel(st, subkey(key_r, kidx)); cnt <= cnt + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf <= '0; ocnt <= '0; xout <= '0;
    end else if (emit) begin
      obuf <= res; ocnt <= 4'(BYTES); xout <= 3'(XFER);
    end else begin
      if (xout != 3'd0) xout <= xout - 3'd1;
      if (rd_ok) begin
        obuf <= {obuf[55:0], 8'd0};
        ocnt <= ocnt - 4'd1;
      end
    end
  end

  p_wr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_rdy && ib == 3'd7) |=> !in_rdy)
    else $error("in_rdy stayed high after the eighth byte");

  p_avail_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_avail) |-> $past(emit, 6))
    else $error("out_avail rose without a core result six clocks earlier");

  p_last_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && out_avail && ocnt == 4'd1) |=> !out_avail)
    else $error("out_avail stayed high after the eighth read");

  p_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !in_rdy && !cfg_ld) |=> (err && $stable(ib)))
    else $error("rejected write changed state or left err low");

  p_rd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !out_avail && !cfg_ld) |=> err)
    else $error("rejected read left err low");
endmodule

// File: tb/test_des_byte_engine.sv
`timescale 1ns/1ps
module test_des_byte_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ld = 1'b0, cfg_dec = 1'b0, cfg_cbc = 1'b0;
  logic [63:0] key_in = '0, iv_in = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  din = '0;
  logic        in_rdy, out_avail, err;
  logic [7:0]  dout;
  int          cyc = 0;
  int          checks = 0, errors = 0;

  localparam logic [63:0] K1 = 64'h133457799BBCDFF1;
  localparam logic [63:0] K2 = 64'h0E329232EA6D0D73;
  localparam logic [63:0] P1 = 64'h0123456789ABCDEF;
  localparam logic [63:0] C1 = 64'h85E813540F0AB405;

  // {dec, cbc, key, iv, block in, block out}
  localparam logic [257:0] VEC [7] = '{
    {1'b0, 1'b0, K1, 64'h0, P1, C1},                                                // R6
    {1'b1, 1'b0, K1, 64'h0, C1, P1},                                                // R7
    {1'b0, 1'b0, K2, 64'h0, 64'h8787878787878787, 64'h0},                           // R6
    {1'b1, 1'b0, K2, 64'h0, 64'h0, 64'h8787878787878787},                           // R7
    {1'b0, 1'b1, K1, 64'h0, P1, C1},                                                // R8
    {1'b0, 1'b1, K2, 64'hFFFFFFFFFFFFFFFF, 64'h7878787878787878, 64'h0},            // R8
    {1'b1, 1'b1, K2, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h7878787878787878}};           // R9

  logic [63:0] s_in [4];
  logic [63:0] s_exp [4];
  logic [63:0] s_out [4];
  int          s_av [4];

  des_byte_engine i_des_byte_engine (
    .clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_dec(cfg_dec), .cfg_cbc(cfg_cbc),
    .key_in(key_in), .iv_in(iv_in), .wr(wr), .din(din), .in_rdy(in_rdy),
    .rd(rd), .dout(dout), .out_avail(out_avail), .err(err));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_cfg(input logic d, input logic c, input logic [63:0] k, input logic [63:0] v);
    @(negedge clk);
    cfg_ld = 1'b1; cfg_dec = d; cfg_cbc = c; key_in = k; iv_in = v;
    @(negedge clk);
    cfg_ld = 1'b0;
  endtask

  task automatic put_block(input logic [63:0] pt, output int s);
    while (!in_rdy) @(negedge clk);
    s = cyc;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      wr = 1'b1; din = pt[63-8*k -: 8];
    end
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic get_block(output logic [63:0] ct, output int t);
    while (!out_avail) @(negedge clk);
    t = cyc;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      ct[63-8*k -: 8] = dout; rd = 1'b1;
    end
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic run_one(input logic [63:0] pt, input logic [63:0] exp, input string tag);
    int s, t;
    logic [63:0] ct;
    put_block(pt, s);
    chk(in_rdy == 1'b0, "R2", "in_rdy low at clock 8", 64'(in_rdy), 64'd0);
    while (!in_rdy) @(negedge clk);
    chk(cyc - s == 13, "R2", "in_rdy return clock", 64'(cyc - s), 64'd13);
    get_block(ct, t);
    chk(t - s == 31, "R3", "out_avail clock", 64'(t - s), 64'd31);
    chk(ct == exp, tag, "R1 result block", ct, exp);
    chk(cyc - s == 39 && !out_avail, "R4", "out_avail low at clock 39",
        64'(cyc - s), 64'd39);
  endtask

  task automatic stream(input int n, input string tag);
    fork
      begin
        int s;
        for (int b = 0; b < n; b++) put_block(s_in[b], s);
      end
      begin
        for (int b = 0; b < n; b++) get_block(s_out[b], s_av[b]);
      end
    join
    for (int b = 0; b < n; b++) begin
      chk(s_out[b] == s_exp[b], tag, "streamed block", s_out[b], s_exp[b]);
      if (b > 0)
        chk(s_av[b] - s_av[b-1] == 18, "R5", "result spacing",
            64'(s_av[b] - s_av[b-1]), 64'd18);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s, t;
    logic [63:0] ct;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_rdy == 1'b1, "R12", "in_rdy after reset", 64'(in_rdy), 64'd1);
    chk(out_avail == 1'b0, "R12", "out_avail after reset", 64'(out_avail), 64'd0);
    chk(err == 1'b0, "R12", "err after reset", 64'(err), 64'd0);

    for (int i = 0; i < 7; i++) begin
      logic [257:0] v;
      string tag;
      v = VEC[i];
      tag = v[257] ? (v[256] ? "R9" : "R7") : (v[256] ? "R8" : "R6");
      do_cfg(v[257], v[256], v[255:192], v[191:128]);
      run_one(v[127:64], v[63:0], tag);
    end

    // R5: four codebook blocks with both ports kept busy
    do_cfg(1'b0, 1'b0, K1, 64'h0);
    for (int b = 0; b < 4; b++) begin s_in[b] = P1; s_exp[b] = C1; end
    stream(4, "R6");

    // R8: chained encryption, second block loaded as the first one leaves the core
    do_cfg(1'b0, 1'b1, K1, 64'h0);
    s_in[0] = P1; s_in[1] = P1 ^ C1; s_exp[0] = C1; s_exp[1] = C1;
    stream(2, "R8");

    // R9: chained decryption of the same pair
    do_cfg(1'b1, 1'b1, K1, 64'h0);
    s_in[0] = C1; s_in[1] = C1; s_exp[0] = P1; s_exp[1] = P1 ^ C1;
    stream(2, "R9");

    // R11: read with nothing available
    do_cfg(1'b0, 1'b0, K1, 64'h0);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(err == 1'b1, "R11", "err after rejected read", 64'(err), 64'd1);
    chk(out_avail == 1'b0, "R11", "out_avail after rejected read", 64'(out_avail), 64'd0);
    @(negedge clk);
    chk(err == 1'b1, "R13", "err stays set", 64'(err), 64'd1);

    // R13: reconfiguration clears err
    do_cfg(1'b0, 1'b0, K1, 64'h0);
    chk(err == 1'b0, "R13", "err cleared by cfg_ld", 64'(err), 64'd0);
    run_one(P1, C1, "R11");

    // R10: write while in_rdy is low
    put_block(P1, s);
    wr = 1'b1; din = 8'hFF;
    @(negedge clk); wr = 1'b0;
    chk(err == 1'b1, "R10", "err after rejected write", 64'(err), 64'd1);
    get_block(ct, t);
    chk(ct == C1, "R10", "block after rejected write", ct, C1);
    run_one(P1, C1, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule